// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Four-Byte Page Write

This block is the bus-facing controller of a small serial EEPROM that holds 128 bytes in on-chip registers. It watches a two-wire bus (a clock line and an open-drain data line). It recognises start and stop conditions and answers when a transfer carries its own seven-bit device identifier. It takes single-byte and four-byte page writes, and it serves reads from the current address, from a freshly written address and in sequence. It pulls the data line low through a single output-enable to acknowledge and to send zero bits.

Write data is first gathered in a four-entry page buffer. The buffer is copied into storage only when a stop condition closes the write, and at that same moment a programming timer starts. Until the timer runs out, the block refuses to acknowledge its own identifier, so a master can poll for completion. The timer length is set in system clock cycles by a parameter.

Top module: `eep_2w_slave`

## Requirements
- R1: After reset the block drives nothing onto the data line, every storage byte reads 0x00 and the internal address counter is 0.
- R2: The first byte after a start holds the identifier in bits 7..1 (default 7'h50) and the direction in bit 0 (0 write, 1 read). A matching byte is acknowledged by pulling the data line low during the ninth clock. A non-matching byte is not acknowledged, and the block stays silent until the next start.
- R3: In a write, the second byte is the word address, of which bits 6..0 are used and bit 7 is ignored. Every following data byte is acknowledged and goes to the page slot selected by the two low address bits. The five upper address bits stay fixed for the rest of the transfer.
- R4: When more than four data bytes arrive before the stop, the two low address bits wrap from 3 to 0, and later bytes overwrite earlier ones in the same page.
- R5: Storage changes only when a stop ends a write that carried at least one complete data byte. A write cut short by a repeated start leaves storage unchanged and does not start the programming timer.
- R6: A committing stop starts a programming period of WR_CYCLES clocks. During that period the identifier is not acknowledged. Once the period has passed it is acknowledged again.
- R7: The block changes its data-line drive only while the clock line is low. It sends read data most significant bit first, pulling low for a 0 and releasing for a 1.
- R8: A read with no word address starts at the internal counter. The counter advances by one after each byte sent and wraps from 127 to 0. After a write it points to the slot after the last written byte, with only the two low bits advancing within the page.
- R9: In a read, a low data line on the ninth clock makes the block send the next byte. A high line makes it release the bus and ignore further clocks until the next start.
- R10: A write of only the word address, followed by a repeated start with the direction bit set, reads from that word address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Properties evaluated on every clock cover the following:
- the drive changes only while the synchronised clock line is low;
- the upper page bits hold across each data byte while the two low bits step by one;
- the read counter steps by one per loaded byte;
- every commit has buffered data behind it and is followed by a busy timer;
- no identifier is acknowledged while that timer runs.

Only the bench scenarios can show the stored byte values: page wrap overwriting, the abort by repeated start leaving storage intact, counter placement after a write, the 127-to-0 roll and the master-driven end of a sequential read. The bench checks these against its own memory model.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W = 7;
  localparam int PAGE_W = 2;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGES  = 1 << PAGE_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [3:0] {
    PH_IDLE, PH_DEV, PH_DACK, PH_WADR, PH_AACK,
    PH_WDAT, PH_WACK, PH_RDAT, PH_RACK
  } ph_e;

  // advance only the in-page bits, upper bits unchanged
  function automatic addr_t page_step(addr_t a);
    return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + 1'b1};
  endfunction

  // advance across the whole space, rolling past the top
  function automatic addr_t seq_step(addr_t a);
    return a + 1'b1;
  endfunction

  function automatic logic id_hit(byte_t b, logic [DATA_W-2:0] id);
    return b[DATA_W-1:1] == id;
  endfunction
endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
  parameter int WR_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left <= '0;
    else if (kick)           left <= CW'(WR_CYCLES);
    else if (left != '0)     left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  addr_t               rd_addr,
  output byte_t               rd_data,
  input  logic                buf_we,
  input  logic [PAGE_W-1:0]   buf_idx,
  input  byte_t               buf_din,
  input  logic                buf_clr,
  input  logic                commit,
  input  logic [ADDR_W-PAGE_W-1:0] page_base
);
  byte_t             mem [DEPTH];
  byte_t             pg  [PAGES];
  logic [PAGES-1:0]  vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int j = 0; j < PAGES; j++) pg[j] <= '0;
      vld <= '0;
    end else begin
      if (commit) begin
        for (int j = 0; j < PAGES; j++)
          if (vld[j]) mem[{page_base, PAGE_W'(j)}] <= pg[j];
        vld <= '0;
      end else if (buf_clr) begin
        vld <= '0;
      end
      if (buf_we) begin
        pg[buf_idx]  <= buf_din;
        vld[buf_idx] <= 1'b1;
      end
    end
  end

  assign rd_data = mem[rd_addr];

  AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (vld != '0)); // R5
endmodule

// File: rtl/eep_proto.sv
module eep_proto
  import eep_pkg::*;
#(
  parameter logic [DATA_W-2:0] DEV_ID = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              busy,
  input  byte_t             rd_data,
  output logic              sda_oe,
  output addr_t             ptr,
  output logic              buf_we,
  output logic [PAGE_W-1:0] buf_idx,
  output byte_t             buf_din,
  output logic              buf_clr,
  output logic              commit,
  output logic              dev_ack,
  output logic              wr_stb,
  output logic              rd_load
);
  localparam logic [3:0] BYTE_BITS = 4'(DATA_W);

  ph_e        ph;
  logic [3:0] bitn;
  byte_t      shreg, txb;
  logic       rw, mack, pend;

  logic rx_phase, rx_shift, rx_done;
  assign rx_phase = (ph == PH_DEV) || (ph == PH_WADR) || (ph == PH_WDAT);
  assign rx_shift = rx_phase && scl_rise && (bitn != BYTE_BITS);
  assign rx_done  = rx_phase && scl_fall && (bitn == BYTE_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; bitn <= '0; shreg <= '0; txb <= '0; ptr <= '0;
      rw <= 1'b0; mack <= 1'b0; pend <= 1'b0; sda_oe <= 1'b0;
      buf_we <= 1'b0; buf_idx <= '0; buf_din <= '0; buf_clr <= 1'b0;
      commit <= 1'b0; dev_ack <= 1'b0; wr_stb <= 1'b0; rd_load <= 1'b0;
    end else begin
      buf_we <= 1'b0; buf_clr <= 1'b0; commit <= 1'b0;
      dev_ack <= 1'b0; wr_stb <= 1'b0; rd_load <= 1'b0;
      if (start_det) begin
        ph <= PH_DEV; bitn <= '0; sda_oe <= 1'b0; pend <= 1'b0; buf_clr <= 1'b1;
      end else if (stop_det) begin
        commit <= pend; ph <= PH_IDLE; sda_oe <= 1'b0; pend <= 1'b0;
      end else if (rx_shift) begin
        shreg <= {shreg[DATA_W-2:0], sda_lvl};
        bitn  <= bitn + 1'b1;
      end else if (rx_done) begin
        bitn <= '0;
        case (ph)
          PH_DEV: begin
            if (id_hit(shreg, DEV_ID) && !busy) begin
              rw <= shreg[0]; sda_oe <= 1'b1; dev_ack <= 1'b1; ph <= PH_DACK;
            end else begin
              ph <= PH_IDLE;
            end
          end
          PH_WADR: begin
            ptr <= shreg[ADDR_W-1:0]; sda_oe <= 1'b1; ph <= PH_AACK;
          end
          default: begin
            buf_we <= 1'b1; buf_idx <= ptr[PAGE_W-1:0]; buf_din <= shreg;
            ptr <= page_step(ptr); pend <= 1'b1; wr_stb <= 1'b1;
            sda_oe <= 1'b1; ph <= PH_WACK;
          end
        endcase
      end else begin
        case (ph)
          PH_DACK: if (scl_fall) begin
            if (rw) begin
              txb <= rd_data; sda_oe <= ~rd_data[DATA_W-1]; ptr <= seq_step(ptr);
              rd_load <= 1'b1; bitn <= '0; ph <= PH_RDAT;
            end else begin
              sda_oe <= 1'b0; ph <= PH_WADR;
            end
          end
          PH_AACK: if (scl_fall) begin sda_oe <= 1'b0; ph <= PH_WDAT; end
          PH_WACK: if (scl_fall) begin sda_oe <= 1'b0; ph <= PH_WDAT; end
          PH_RDAT: begin
            if (scl_rise) bitn <= bitn + 1'b1;
            else if (scl_fall) begin
              if (bitn == BYTE_BITS) begin
                sda_oe <= 1'b0; bitn <= '0; ph <= PH_RACK;
              end else begin
                txb <= {txb[DATA_W-2:0], 1'b0}; sda_oe <= ~txb[DATA_W-2];
              end
            end
          end
          PH_RACK: begin
            if (scl_rise) mack <= ~sda_lvl;
            else if (scl_fall) begin
              if (mack) begin
                txb <= rd_data; sda_oe <= ~rd_data[DATA_W-1]; ptr <= seq_step(ptr);
                rd_load <= 1'b1; bitn <= '0; ph <= PH_RDAT;
              end else begin
                ph <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])); // R3
  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1'b1)); // R4
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |-> ptr == ADDR_W'($past(ptr) + 1'b1)); // R8
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl); // R7
endmodule

// File: rtl/eep_2w_slave.sv
module eep_2w_slave
  import eep_pkg::*;
#(
  parameter logic [DATA_W-2:0] DEV_ID = 7'h50,
  parameter int WR_CYCLES = 625000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic busy, buf_we, buf_clr, commit, dev_ack, wr_stb, rd_load;
  logic [PAGE_W-1:0] buf_idx;
  byte_t buf_din, rd_data;
  addr_t ptr;

  eep_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  eep_proto #(.DEV_ID(DEV_ID)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe_o),
    .ptr(ptr), .buf_we(buf_we), .buf_idx(buf_idx), .buf_din(buf_din),
    .buf_clr(buf_clr), .commit(commit), .dev_ack(dev_ack), .wr_stb(wr_stb),
    .rd_load(rd_load)
  );

  eep_store u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(ptr), .rd_data(rd_data),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_din(buf_din), .buf_clr(buf_clr),
    .commit(commit), .page_base(ptr[ADDR_W-1:PAGE_W])
  );

  eep_wtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(commit), .busy(busy)
  );

  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy); // R6
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dev_ack); // R6
endmodule

// File: tb/eep_2w_slave_tb_top.sv
module eep_2w_slave_tb_top;
  localparam int HALF = 16;
  localparam int QTR  = 8;
  localparam int WRC  = 600;
  localparam logic [6:0] ID = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  eep_2w_slave #(.DEV_ID(ID), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, mon_err = 0, mon_win = 0, mon_last = -1;
  logic mon_exp = 1'b0, mon_on = 1'b0;

  logic [7:0] m_mem [128];
  logic [7:0] m_pg [4];
  bit         m_v [4];
  int         m_ptr = 0, busy_end = -1000;
  logic [7:0] wq [$];

  // per-clock comparison of the drive against the expected bit while SCL is high
  always @(negedge clk)
    if (mon_on && scl_m && rst_n && (sda_oe !== mon_exp) && (mon_win != mon_last)) begin
      mon_last = mon_win;
      mon_err++;
      $display("FAIL R7 drive in high phase actual=%0b expected=%0b", sda_oe, mon_exp);
    end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    mon_exp = 1'b0; mon_win++;
    sda_m = 1'b1; tick(QTR); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF); scl_m = 1'b0; tick(QTR);
  endtask

  task automatic bus_stop;
    mon_exp = 1'b0; mon_win++;
    sda_m = 1'b0; tick(QTR); scl_m = 1'b1; tick(HALF); sda_m = 1'b1; tick(HALF);
  endtask

  task automatic clk_bit(input bit drv, input bit exp_oe, output bit got);
    sda_m = drv; mon_exp = exp_oe; mon_win++;
    tick(QTR); scl_m = 1'b1; tick(HALF/2); got = sda_line;
    tick(HALF/2); scl_m = 1'b0; tick(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit g;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, g);
    clk_bit(1'b1, exp_ack, g);
    check((!g) == exp_ack, req, "acknowledge", int'(!g), int'(exp_ack));
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit give_ack, input string req);
    bit g;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, ~exp[i], g); v[i] = g; end
    clk_bit(!give_ack, 1'b0, g);
    check(v == exp, req, "read byte", int'(v), int'(exp));
  endtask

  task automatic wait_ready; while (cyc < busy_end + 60) tick(1); endtask

  task automatic m_write(input int a);
    wait_ready;
    bus_start;
    send_byte({ID, 1'b0}, 1'b1, "R2");
    send_byte(8'(a), 1'b1, "R3");
    m_ptr = a % 128;
    foreach (wq[k]) begin
      send_byte(wq[k], 1'b1, "R3");
      m_pg[m_ptr % 4] = wq[k]; m_v[m_ptr % 4] = 1;
      m_ptr = (m_ptr / 4) * 4 + (m_ptr + 1) % 4;
    end
    bus_stop;
    for (int j = 0; j < 4; j++) begin
      if (m_v[j]) m_mem[(m_ptr / 4) * 4 + j] = m_pg[j];
      m_v[j] = 0;
    end
    if (wq.size() > 0) busy_end = cyc + WRC;
  endtask

  task automatic m_set_addr(input int a);
    wait_ready;
    bus_start;
    send_byte({ID, 1'b0}, 1'b1, "R10");
    send_byte(8'(a), 1'b1, "R10");
    m_ptr = a % 128;
  endtask

  task automatic m_read(input int n, input string req);
    wait_ready;
    bus_start;
    send_byte({ID, 1'b1}, 1'b1, "R2");
    for (int k = 0; k < n; k++) begin
      recv_byte(m_mem[m_ptr], k != n - 1, req);
      m_ptr = (m_ptr + 1) % 128;
    end
    bus_stop;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
    for (int j = 0; j < 4; j++) m_v[j] = 0;
    tick(10);
    check(sda_oe == 1'b0, "R1", "drive in reset", int'(sda_oe), 0);
    rst_n = 1'b1; mon_on = 1'b1;
    tick(20);
    check(sda_oe == 1'b0, "R1", "drive after reset", int'(sda_oe), 0);
    m_read(1, "R1");                       // counter 0, contents cleared

    bus_start;                             // foreign identifier
    send_byte({ID ^ 7'h01, 1'b0}, 1'b0, "R2");
    send_byte(8'h00, 1'b0, "R2");          // stays silent
    bus_stop;

    wq = '{8'h3C};
    m_write(8'h85);                        // bit 7 of word address ignored (R3)
    bus_start;                             // immediate poll, still programming
    send_byte({ID, 1'b0}, 1'b0, "R6");
    bus_stop;
    wait_ready;
    bus_start;
    send_byte({ID, 1'b0}, 1'b1, "R6");
    bus_stop;
    m_set_addr(8'h05);
    m_read(1, "R10");

    wq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    m_write(8'h0A);                        // six bytes into a four-byte page
    m_set_addr(8'h08);
    m_read(5, "R4");                       // sequential read, also R9 acks

    wait_ready;                            // aborted write
    bus_start;
    send_byte({ID, 1'b0}, 1'b1, "R5");
    send_byte(8'h20, 1'b1, "R5");
    send_byte(8'hAA, 1'b1, "R5");
    m_ptr = 8'h21;
    m_read(1, "R5");                       // repeated start aborts
    bus_start;
    send_byte({ID, 1'b0}, 1'b1, "R5");     // no programming period started
    bus_stop;
    m_set_addr(8'h20);
    m_read(1, "R5");

    wq = '{8'h77}; m_write(8'h30);
    wq = '{8'h88}; m_write(8'h33);
    m_read(1, "R8");                       // counter wrapped inside page to 0x30

    wq = '{8'h1E}; m_write(8'h00);
    wq = '{8'hE1}; m_write(8'h7F);
    m_set_addr(8'h7F);
    m_read(2, "R8");                       // 127 rolls to 0

    m_set_addr(8'h08);
    bus_start;
    send_byte({ID, 1'b1}, 1'b1, "R9");
    recv_byte(m_mem[8], 1'b0, "R9");       // master leaves line high
    recv_byte(8'hFF, 1'b0, "R9");          // block must stay released
    bus_stop;

    check(mon_err == 0, "R7", "high-phase drive mismatches", mon_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    $display("FAIL watchdog R1 actual=%0d cycles expected=completion", cyc);
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end
endmodule